// File: doc/BRIEF.md
# Comparison Condition Bank

This block turns a single compare of two operands into a bank of twelve independent condition bits. Each bit is a ready-made predicate (equal, unsigned lower, signed greater, and so on), so that a later conditional branch or conditional move reads one bit and needs no flag decoding. The second operand arrives already produced by the operand shifter; the block does not shift or select it.

Two modes exist. In integer mode the low 32 bits of each operand are compared both as unsigned and as two's-complement numbers. In float mode the full 64-bit operands are compared as IEEE-754 double-precision values. A NaN on either side makes the result unordered, and positive and negative zero compare equal. Each mode leaves one pair of bits without meaning. A per-bit valid mask travels with the bank, so that a consumer reading an undefined bit can be caught.

The bank and its mask are loaded together on a clock edge with the write enable high. They keep their contents otherwise.

Top module: `cond_bank_unit`

## Requirements
- R1: A synchronous active-high reset clears all twelve condition bits and all twelve valid bits to zero.
- R2: While `wr_en_i` is low, `cond_o` and `cond_vld_o` keep their values whatever the operands and mode do. With `wr_en_i` high, the result of the current operands and mode appears on both outputs one clock edge later.
- R3: The bit positions are 0 eq, 1 ne, 2 lt, 3 ge, 4 gt, 5 le, 6 lo, 7 hs, 8 hi, 9 ls, 10 mi, 11 pl. Bits 2k and 2k+1 form a pair. When a pair is valid, exactly one of its two bits is set.
- R4: In integer mode (`fp_mode_i`=0), lo = A<B, hs = A>=B, hi = A>B and ls = A<=B. All four are unsigned compares of bits [31:0]. Bits [63:32] have no effect.
- R5: In integer mode, lt, ge, gt and le are the signed two's-complement compares of bits [31:0].
- R6: In integer mode, mi and pl are invalid. Their valid bits are 0, the bits read 0, and the other ten valid bits are 1.
- R7: In float mode (`fp_mode_i`=1), mi = A<B, pl = NOT mi, ls = A<=B, hi = NOT ls, ge = A>=B, lt = NOT ge, gt = A>B and le = NOT gt. The compares are on the 64-bit doubles.
- R8: In float mode, lo and hs are invalid. Their valid bits are 0, the bits read 0, and the other ten valid bits are 1.
- R9: In float mode, a NaN operand (exponent all ones with a non-zero fraction) gives eq, ge, gt, ls and mi equal to 0, and ne, pl, hi, lt and le equal to 1.
- R10: In float mode, +0 and -0 compare equal. This sets eq, ge, ls and pl, and clears lt-style bits accordingly.
- R11: eq is 1 and ne is 0 exactly when the operands are equal under the current mode's rules: integer mode over bits [31:0], float mode as numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa_i | input | 64 | Operand A (integer mode uses bits [31:0]) |
| opb_i | input | 64 | Operand B from the operand shifter |
| fp_mode_i | input | 1 | 0 integer compare, 1 double-precision compare |
| wr_en_i | input | 1 | Load the bank with the current compare result |
| cond_o | output | 12 | Registered condition bits, positions per R3 |
| cond_vld_o | output | 12 | Registered per-bit valid mask |

## Verification
Every cycle, the assertions check the following: the pair complement and invalid-reads-zero structure of the bank, the ten-of-twelve shape of the mask, hold without write, and reset clearing. They also check the mode masks and the NaN outcome of the eq/ne pair. The numeric correctness of each predicate shows only in the bench. Those sweeps cover all ordered pairs of integer corner values with noisy upper halves, and all pairs of a double set that holds both zeros, subnormals, infinities and NaNs. The expected values come from native 32-bit and real-number compares.

// File: rtl/cond_bank_pkg.sv
package cond_bank_pkg;

    parameter int INT_W    = 32;
    parameter int FP_EXP_W = 11;
    parameter int FP_MAN_W = 52;
    parameter int FP_W     = 1 + FP_EXP_W + FP_MAN_W;
    parameter int OPND_W   = (FP_W > INT_W) ? FP_W : INT_W;
    parameter int NUM_COND = 12;
    parameter int NUM_PAIR = NUM_COND / 2;

    // condition positions: even = pair leader, odd = its complement
    localparam int C_EQ = 0;
    localparam int C_NE = 1;
    localparam int C_LT = 2;
    localparam int C_GE = 3;
    localparam int C_GT = 4;
    localparam int C_LE = 5;
    localparam int C_LO = 6;
    localparam int C_HS = 7;
    localparam int C_HI = 8;
    localparam int C_LS = 9;
    localparam int C_MI = 10;
    localparam int C_PL = 11;

    localparam int P_EQ = C_EQ / 2;
    localparam int P_LT = C_LT / 2;
    localparam int P_GT = C_GT / 2;
    localparam int P_LO = C_LO / 2;
    localparam int P_HI = C_HI / 2;
    localparam int P_MI = C_MI / 2;

    typedef logic [NUM_COND-1:0] cond_vec_t;
    typedef logic [NUM_PAIR-1:0] pair_vec_t;

    typedef enum logic {
        MODE_INT = 1'b0,
        MODE_FP  = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic eq;
        logic lt_s;
        logic gt_s;
        logic lt_u;
        logic gt_u;
    } int_rel_t;

    typedef struct packed {
        logic unord;
        logic eq;
        logic lt;
        logic gt;
    } fp_rel_t;

    typedef struct packed {
        cond_vec_t val;
        cond_vec_t vld;
    } cond_bank_t;

    // one bit set per pair index
    function automatic pair_vec_t pair_bit(input int idx);
        pair_vec_t r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/int_rel_cmp.sv
module int_rel_cmp
    import cond_bank_pkg::*;
#(
    parameter int W = INT_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output int_rel_t     rel_o
);
    logic sign_diff;
    logic mag_lt;

    always_comb begin
        sign_diff = a_i[W-1] ^ b_i[W-1];
        mag_lt    = a_i[W-2:0] < b_i[W-2:0];

        rel_o.eq   = (a_i == b_i);
        rel_o.lt_u = sign_diff ? b_i[W-1] : mag_lt;
        rel_o.gt_u = !rel_o.eq && !rel_o.lt_u;
        // with differing signs the negative side is the smaller one
        rel_o.lt_s = sign_diff ? a_i[W-1] : mag_lt;
        rel_o.gt_s = !rel_o.eq && !rel_o.lt_s;
    end
endmodule

// File: rtl/fp_rel_cmp.sv
module fp_rel_cmp
    import cond_bank_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int MAN_W = FP_MAN_W
) (
    input  logic [EXP_W+MAN_W:0] a_i,
    input  logic [EXP_W+MAN_W:0] b_i,
    output fp_rel_t              rel_o
);
    localparam int W     = 1 + EXP_W + MAN_W;
    localparam int MAG_W = W - 1;

    logic             sa, sb;
    logic [MAG_W-1:0] ma, mb;
    logic             nan_a, nan_b, zeros, raw_eq, raw_lt;

    always_comb begin
        sa    = a_i[W-1];
        sb    = b_i[W-1];
        ma    = a_i[MAG_W-1:0];
        mb    = b_i[MAG_W-1:0];
        nan_a = (&a_i[W-2:MAN_W]) && (|a_i[MAN_W-1:0]);
        nan_b = (&b_i[W-2:MAN_W]) && (|b_i[MAN_W-1:0]);
        zeros = (ma == '0) && (mb == '0);
        raw_eq = zeros || (a_i == b_i);

        if (zeros)         raw_lt = 1'b0;
        else if (sa != sb) raw_lt = sa;
        else if (!sa)      raw_lt = ma < mb;
        else               raw_lt = mb < ma;

        rel_o.unord = nan_a || nan_b;
        rel_o.eq    = !rel_o.unord && raw_eq;
        rel_o.lt    = !rel_o.unord && raw_lt;
        rel_o.gt    = !rel_o.unord && !raw_eq && !raw_lt;
    end
endmodule

// File: rtl/cond_map.sv
module cond_map
    import cond_bank_pkg::*;
(
    input  int_rel_t   irel_i,
    input  fp_rel_t    frel_i,
    input  cmp_mode_e  mode_i,
    output cond_bank_t bank_o
);
    pair_vec_t lead;
    pair_vec_t pvld;

    always_comb begin
        lead = '0;
        if (mode_i == MODE_FP) begin
            pvld       = ~pair_bit(P_LO);
            lead[P_EQ] = frel_i.eq;
            lead[P_LT] = !(frel_i.gt || frel_i.eq);    // lt = NOT ge
            lead[P_GT] = frel_i.gt;
            lead[P_HI] = !(frel_i.lt || frel_i.eq);    // hi = NOT ls
            lead[P_MI] = frel_i.lt;
        end else begin
            pvld       = ~pair_bit(P_MI);
            lead[P_EQ] = irel_i.eq;
            lead[P_LT] = irel_i.lt_s;
            lead[P_GT] = irel_i.gt_s;
            lead[P_LO] = irel_i.lt_u;
            lead[P_HI] = irel_i.gt_u;
        end
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        assign bank_o.val[2*p]   = pvld[p] &  lead[p];
        assign bank_o.val[2*p+1] = pvld[p] & ~lead[p];
        assign bank_o.vld[2*p]   = pvld[p];
        assign bank_o.vld[2*p+1] = pvld[p];
    end
endmodule

// File: rtl/cond_bank_unit.sv
module cond_bank_unit
    import cond_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OPND_W-1:0]   opa_i,
    input  logic [OPND_W-1:0]   opb_i,
    input  logic                fp_mode_i,
    input  logic                wr_en_i,
    output logic [NUM_COND-1:0] cond_o,
    output logic [NUM_COND-1:0] cond_vld_o
);
    int_rel_t   irel;
    fp_rel_t    frel;
    cond_bank_t nxt;
    cond_bank_t bank_q;
    cmp_mode_e  mode;

    assign mode = fp_mode_i ? MODE_FP : MODE_INT;

    int_rel_cmp #(.W(INT_W)) u_int (
        .a_i   (opa_i[INT_W-1:0]),
        .b_i   (opb_i[INT_W-1:0]),
        .rel_o (irel)
    );

    fp_rel_cmp #(.EXP_W(FP_EXP_W), .MAN_W(FP_MAN_W)) u_fp (
        .a_i   (opa_i[FP_W-1:0]),
        .b_i   (opb_i[FP_W-1:0]),
        .rel_o (frel)
    );

    cond_map u_map (
        .irel_i (irel),
        .frel_i (frel),
        .mode_i (mode),
        .bank_o (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)          bank_q <= '0;
        else if (wr_en_i) bank_q <= nxt;
    end

    assign cond_o     = bank_q.val;
    assign cond_vld_o = bank_q.vld;

    // ---------------- assertions ----------------
    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_seen_q && !rst) begin
            a_r1_reset_clears: assert (cond_o == '0 && cond_vld_o == '0)
                else $error("bank not cleared by reset");
        end
    end

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> ($stable(cond_o) && $stable(cond_vld_o)));

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair_chk
        a_r3_pair_complement: assert property (@(posedge clk) disable iff (rst)
            (cond_vld_o[2*p] && cond_vld_o[2*p+1]) |->
                $onehot({cond_o[2*p], cond_o[2*p+1]}));
        a_r3_pair_vld_together: assert property (@(posedge clk) disable iff (rst)
            cond_vld_o[2*p] == cond_vld_o[2*p+1]);
    end

    a_r6_invalid_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (cond_o & ~cond_vld_o) == '0);

    a_r8_mask_shape: assert property (@(posedge clk) disable iff (rst)
        $countones(cond_vld_o) == 0 || $countones(cond_vld_o) == NUM_COND - 2);

    a_r6_int_mask: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !fp_mode_i) |=>
            (!cond_vld_o[C_MI] && !cond_vld_o[C_PL] && cond_vld_o[C_LO]));

    a_r8_fp_mask: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && fp_mode_i) |=>
            (!cond_vld_o[C_LO] && !cond_vld_o[C_HS] && cond_vld_o[C_MI]));

    a_r9_nan_unequal: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && fp_mode_i && (&opa_i[FP_W-2:FP_MAN_W]) && (|opa_i[FP_MAN_W-1:0])) |=>
            (!cond_o[C_EQ] && cond_o[C_NE] && cond_o[C_LE] && cond_o[C_LT]));

    a_r11_int_equal: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !fp_mode_i && opa_i[INT_W-1:0] == opb_i[INT_W-1:0]) |=>
            (cond_o[C_EQ] && !cond_o[C_NE] && cond_o[C_HS] && cond_o[C_LE]));

endmodule

// File: tb/cond_bank_unit_tb_top.sv
module cond_bank_unit_tb_top;

    localparam int EQ = 0, NE = 1, LT = 2, GE = 3, GT = 4, LE = 5;
    localparam int LO = 6, HS = 7, HI = 8, LS = 9, MI = 10, PL = 11;
    localparam logic [11:0] M_EQNE = 12'h003;
    localparam logic [11:0] M_SGN  = 12'h03C;
    localparam logic [11:0] M_UNS  = 12'h3C0;
    localparam logic [11:0] M_MIPL = 12'hC00;
    localparam logic [11:0] M_ALL  = 12'hFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] opa = '0, opb = '0;
    logic        fp_mode = 1'b0, wr_en = 1'b0;
    logic [11:0] cond, vld;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cond_bank_unit dut_i (
        .clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb),
        .fp_mode_i(fp_mode), .wr_en_i(wr_en),
        .cond_o(cond), .cond_vld_o(vld)
    );

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [11:0] mask,
                       input logic [11:0] ev, input logic [11:0] em);
        checks++;
        if (((cond & mask) != (ev & mask)) || ((vld & mask) != (em & mask))) begin
            errors++;
            $display("FAIL %s: cond %h vld %h expected cond %h vld %h (mask %h)",
                     tag, cond & mask, vld & mask, ev & mask, em & mask, mask);
        end
    endtask

    task automatic write_op(input logic [63:0] a, input logic [63:0] b, input logic fp);
        @(negedge clk);
        opa = a; opb = b; fp_mode = fp; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [11:0] exp_int(input logic [63:0] a, input logic [63:0] b);
        logic [11:0] e;
        logic [31:0] x, y;
        x = a[31:0]; y = b[31:0];
        e = '0;
        e[EQ] = x == y;                      e[NE] = x != y;
        e[LT] = $signed(x) <  $signed(y);    e[GE] = $signed(x) >= $signed(y);
        e[GT] = $signed(x) >  $signed(y);    e[LE] = $signed(x) <= $signed(y);
        e[LO] = x <  y;  e[HS] = x >= y;  e[HI] = x > y;  e[LS] = x <= y;
        return e;
    endfunction

    function automatic logic [11:0] exp_fp(input logic [63:0] a, input logic [63:0] b);
        logic [11:0] e;
        real ra, rb;
        ra = $bitstoreal(a); rb = $bitstoreal(b);
        e = '0;
        e[EQ] = ra == rb;     e[NE] = !(ra == rb);
        e[MI] = ra <  rb;     e[PL] = !(ra <  rb);
        e[LS] = ra <= rb;     e[HI] = !(ra <= rb);
        e[GE] = ra >= rb;     e[LT] = !(ra >= rb);
        e[GT] = ra >  rb;     e[LE] = !(ra >  rb);
        return e;
    endfunction

    function automatic logic is_nan(input logic [63:0] v);
        real r;
        r = $bitstoreal(v);
        return r != r;
    endfunction

    logic [31:0] ivals [10];
    logic [63:0] fvals [14];

    initial begin
        logic [11:0] ev, em;
        ivals = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                  32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678, 32'hFFFF_FFFE,
                  32'h0000_0002, 32'hEDCB_A988};
        fvals = '{64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000,
                  64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000,
                  64'h4000_0000_0000_0000, 64'hC000_0000_0000_0000,
                  64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
                  64'h7FF8_0000_0000_0000, 64'hFFF8_0000_0000_0001,
                  64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001,
                  64'h7FEF_FFFF_FFFF_FFFF, 64'h3FE0_0000_0000_0000};

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset", M_ALL, '0, '0);

        // integer sweep: R4 R5 R6 R11, noisy upper halves (R4 ignored bits)
        for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 10; j++) begin
                logic [63:0] a, b;
                a = {32'hA5A5_0000 ^ (i * 32'h0101_3301), ivals[i]};
                b = {32'h5A5A_FFFF ^ (j * 32'h7013_0007), ivals[j]};
                write_op(a, b, 1'b0);
                ev = exp_int(a, b);
                em = ~M_MIPL;
                chk("R11 int eq/ne", M_EQNE, ev, em);
                chk("R5 int signed", M_SGN, ev, em);
                chk("R4 int unsigned", M_UNS, ev, em);
                chk("R6 int mi/pl invalid", M_MIPL, ev, em);
            end
        end

        // float sweep: R7 R8 R9 R10 R11
        for (int i = 0; i < 14; i++) begin
            for (int j = 0; j < 14; j++) begin
                logic [63:0] a, b;
                a = fvals[i]; b = fvals[j];
                write_op(a, b, 1'b1);
                ev = exp_fp(a, b);
                em = ~(M_UNS & 12'h0C0);
                if (is_nan(a) || is_nan(b))
                    chk("R9 fp unordered", M_ALL & ~12'h0C0, ev, em);
                else if (i < 2 && j < 2)
                    chk("R10 fp signed zeros", M_ALL & ~12'h0C0, ev, em);
                else
                    chk("R7 fp ordered", M_SGN | M_MIPL | 12'h300, ev, em);
                chk("R11 fp eq/ne", M_EQNE, ev, em);
                chk("R8 fp lo/hs invalid", 12'h0C0, ev, em);
            end
        end

        // R2: hold while write enable is low
        write_op(64'd5, 64'd3, 1'b0);
        ev = exp_int(64'd5, 64'd3);
        @(negedge clk);
        opa = 64'h8000_0000_0000_0000; opb = 64'h7FF8_0000_0000_0000; fp_mode = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 hold", M_ALL, ev, ~M_MIPL);
        opa = 64'd0; opb = 64'd0; fp_mode = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 hold", M_ALL, ev, ~M_MIPL);

        // R3: complement pairs on a written value
        write_op(64'd1, 64'd2, 1'b0);
        checks++;
        for (int p = 0; p < 5; p++) begin
            if (cond[2*p] == cond[2*p+1]) begin
                errors++;
                $display("FAIL R3 pair %0d: actual %b%b expected complementary", p,
                         cond[2*p], cond[2*p+1]);
            end
        end

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid-run", M_ALL, '0, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule